// File: doc/BRIEF.md
# Paged Stack Push/Pull Engine

This block keeps the stack pointer of an 8-bit microcontroller core and turns it into a full 16-bit memory address. The pointer is only six bits wide. The ten upper address bits are a fixed page value, so the stack always lies in the 64 bytes from `0x00C0` to `0x00FF`. The pointer always names the next free byte. When it runs past either end of the page it wraps around without any warning, and older contents are overwritten.

The core asks the engine for one of four multi-byte sequences:

- a subroutine call, which saves the two program-counter bytes;
- an interrupt entry, which saves the program counter, index register, accumulator and condition codes;
- a subroutine return;
- an interrupt return.

The engine moves one byte per clock cycle. It drives the address and write data with a write strobe, or the address with a read strobe, and takes the read data back from memory. It rebuilds the restored register values and raises a one-cycle completion pulse. A separate command puts the pointer back at the top of the page. Requests that arrive while a sequence is running are dropped.

Top module: `stk_engine`

## Requirements
- R1: After reset, and after a reset-pointer command that is accepted while idle, the idle address is `0x00FF`. After reset the restored-register outputs read zero.
- R2: Every address that is driven has bits 15..6 equal to `0000000011`, so every address lies in `0x00C0`..`0x00FF`. The pointer supplies bits 5..0.
- R3: A push writes at the pointer's current location and then decrements the pointer. A pull first increments the pointer and then reads at the new location. While idle, the address shows the pointer's location.
- R4: The pointer counts modulo 64. A push at `0x00C0` is followed by one at `0x00FF`, and nothing is flagged.
- R5: A call writes two bytes: `pc_in[7:0]` first, then `pc_in[15:8]`.
- R6: An interrupt entry writes five bytes in this order: `pc_in[7:0]`, `pc_in[15:8]`, `x_in`, `acc_in`, `ccr_in`.
- R7: A subroutine return reads the high program-counter byte first and then the low byte, and presents them on `pc_out`.
- R8: An interrupt return reads condition codes, accumulator, index, PC high and PC low in that order, and presents them on `ccr_out`, `acc_out`, `x_out` and `pc_out`.
- R9: A sequence moves exactly one byte per cycle, starting in the cycle after the request is accepted. Its strobe is high for one cycle per byte. The write strobe and the read strobe are never high together, and both are low while idle.
- R10: `done` is high for exactly one cycle: the cycle right after the last byte of a sequence.
- R11: Every request input, including the reset-pointer command, is ignored while a sequence is running.
- R12: When several inputs are raised in the same idle cycle, one wins by priority. From highest to lowest: reset-pointer, interrupt entry, call, interrupt return, return.
- R13: A request presented in the cycle where `done` is high is accepted, so its first byte follows with no gap.
- R14: The register values that a push saves are sampled in the cycle the request is accepted. Changes on those inputs later in the sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_cmd | input | 1 | Put the pointer back at the page top |
| call_req | input | 1 | Start a two-byte call push |
| intr_req | input | 1 | Start a five-byte interrupt push |
| ret_req | input | 1 | Start a two-byte return pull |
| reti_req | input | 1 | Start a five-byte interrupt-return pull |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | Index register to save |
| acc_in | input | 8 | Accumulator to save |
| ccr_in | input | 8 | Condition codes to save |
| mem_rdata | input | 8 | Read data for the address being driven |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Byte being pushed |
| mem_we | output | 1 | Write strobe, one cycle per pushed byte |
| mem_re | output | 1 | Read strobe, one cycle per pulled byte |
| pc_out | output | 16 | Restored program counter |
| x_out | output | 8 | Restored index register |
| acc_out | output | 8 | Restored accumulator |
| ccr_out | output | 8 | Restored condition codes |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two things can land in the same cycle: the completion pulse of one sequence and the acceptance of the next request. The bench starts every new sequence in the `done` cycle of the previous one. It checks that the first byte of the new frame appears in the very next cycle, at the address that follows from the old frame's final pointer. A second collision is a burst of every request input, raised halfway through a running interrupt push. That push must finish unchanged, and the idle address afterwards must show that neither a new frame nor a pointer reset took effect. Expected addresses and bytes come from a shadow pointer and a shadow page kept in the bench.

// File: rtl/stk_pkg.sv
package stk_pkg;

   localparam int unsigned FRAME_MAX = 5;
   localparam int unsigned STEP_W    = $clog2(FRAME_MAX);

   typedef enum logic [2:0] {
      OP_NONE,
      OP_CALL,
      OP_INTR,
      OP_RET,
      OP_RETI
   } op_e;

   typedef enum logic [2:0] {
      SEL_PCL,
      SEL_PCH,
      SEL_X,
      SEL_A,
      SEL_CCR
   } sel_e;

   function automatic logic [STEP_W-1:0] frame_len(op_e op);
      case (op)
         OP_CALL, OP_RET:  return STEP_W'(2);
         OP_INTR, OP_RETI: return STEP_W'(5);
         default:          return '0;
      endcase
   endfunction

   function automatic logic is_push(op_e op);
      return (op == OP_CALL) || (op == OP_INTR);
   endfunction

   // Push order by slot: PCL, PCH, X, A, CCR. Pulls walk it backwards.
   function automatic sel_e slot_sel(logic [STEP_W-1:0] slot);
      case (slot)
         STEP_W'(0): return SEL_PCL;
         STEP_W'(1): return SEL_PCH;
         STEP_W'(2): return SEL_X;
         STEP_W'(3): return SEL_A;
         default:    return SEL_CCR;
      endcase
   endfunction

   function automatic sel_e byte_sel(op_e op, logic [STEP_W-1:0] step);
      case (op)
         OP_RETI: return slot_sel(STEP_W'(4) - step);
         OP_RET:  return slot_sel(STEP_W'(1) - step);
         default: return slot_sel(step);
      endcase
   endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
   parameter int unsigned PTR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_top,
   input  logic             dec,
   input  logic             inc,
   output logic [PTR_W-1:0] sp_q,
   output logic [PTR_W-1:0] sp_up
);

   localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};
   localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

   assign sp_up = sp_q + ONE;

   always_ff @(posedge clk) begin
      if (!rst_n)        sp_q <= TOP;
      else if (load_top) sp_q <= TOP;
      else if (dec)      sp_q <= sp_q - ONE;
      else if (inc)      sp_q <= sp_up;
   end

endmodule

// File: rtl/stk_ctl.sv
module stk_ctl
   import stk_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_cmd,
   input  logic              call_req,
   input  logic              intr_req,
   input  logic              ret_req,
   input  logic              reti_req,
   output op_e               op_q,
   output logic [STEP_W-1:0] step_q,
   output logic              busy_q,
   output logic              start,
   output logic              rsp_go,
   output logic              done_q
);

   op_e  nxt_op;
   logic last;

   // Priority among requests seen in the same idle cycle.
   always_comb begin
      nxt_op = OP_NONE;
      rsp_go = 1'b0;
      if (!busy_q) begin
         if (rsp_cmd)       rsp_go = 1'b1;
         else if (intr_req) nxt_op = OP_INTR;
         else if (call_req) nxt_op = OP_CALL;
         else if (reti_req) nxt_op = OP_RETI;
         else if (ret_req)  nxt_op = OP_RET;
      end
   end

   assign start = (nxt_op != OP_NONE);
   assign last  = busy_q && (step_q == frame_len(op_q) - STEP_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         op_q   <= OP_NONE;
         step_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (start) begin
            busy_q <= 1'b1;
            op_q   <= nxt_op;
            step_q <= '0;
         end else if (busy_q) begin
            if (last) begin
               busy_q <= 1'b0;
               op_q   <= OP_NONE;
               step_q <= '0;
            end else begin
               step_q <= step_q + STEP_W'(1);
            end
         end
      end
   end

   // R11
   hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last) |=> (op_q == $past(op_q)));

   // R10
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/stk_frame.sv
module stk_frame
   import stk_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PC_W     = 16,
   parameter bit          SNAPSHOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] ccr_in,
   input  sel_e              sel,
   output logic [DATA_W-1:0] wdata
);

   logic [DATA_W-1:0] pcl_v, pch_v, x_v, a_v, c_v;

   generate
      if (SNAPSHOT) begin : g_snap
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pcl_v <= '0;
               pch_v <= '0;
               x_v   <= '0;
               a_v   <= '0;
               c_v   <= '0;
            end else if (capture) begin
               pcl_v <= pc_in[DATA_W-1:0];
               pch_v <= pc_in[PC_W-1:DATA_W];
               x_v   <= x_in;
               a_v   <= acc_in;
               c_v   <= ccr_in;
            end
         end
      end else begin : g_live
         assign pcl_v = pc_in[DATA_W-1:0];
         assign pch_v = pc_in[PC_W-1:DATA_W];
         assign x_v   = x_in;
         assign a_v   = acc_in;
         assign c_v   = ccr_in;
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_PCL: wdata = pcl_v;
         SEL_PCH: wdata = pch_v;
         SEL_X:   wdata = x_v;
         SEL_A:   wdata = a_v;
         default: wdata = c_v;
      endcase
   end

endmodule

// File: rtl/stk_restore.sv
module stk_restore
   import stk_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PC_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  sel_e              sel,
   input  logic [DATA_W-1:0] rdata,
   output logic [PC_W-1:0]   pc_out,
   output logic [DATA_W-1:0] x_out,
   output logic [DATA_W-1:0] acc_out,
   output logic [DATA_W-1:0] ccr_out
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_out  <= '0;
         x_out   <= '0;
         acc_out <= '0;
         ccr_out <= '0;
      end else if (take) begin
         case (sel)
            SEL_PCL: pc_out[DATA_W-1:0]    <= rdata;
            SEL_PCH: pc_out[PC_W-1:DATA_W] <= rdata;
            SEL_X:   x_out                 <= rdata;
            SEL_A:   acc_out               <= rdata;
            default: ccr_out               <= rdata;
         endcase
      end
   end

endmodule

// File: rtl/stk_engine.sv
module stk_engine
   import stk_pkg::*;
#(
   parameter int unsigned                    DATA_W   = 8,
   parameter int unsigned                    PC_W     = 16,
   parameter int unsigned                    ADDR_W   = 16,
   parameter int unsigned                    PTR_W    = 6,
   parameter logic [ADDR_W-PTR_W-1:0]        PAGE_VAL = 10'b0000000011,
   parameter bit                             SNAPSHOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_cmd,
   input  logic              call_req,
   input  logic              intr_req,
   input  logic              ret_req,
   input  logic              reti_req,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] ccr_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   output logic [PC_W-1:0]   pc_out,
   output logic [DATA_W-1:0] x_out,
   output logic [DATA_W-1:0] acc_out,
   output logic [DATA_W-1:0] ccr_out,
   output logic              done
);

   localparam int unsigned PAGE_W = ADDR_W - PTR_W;

   generate
      if (PC_W != 2 * DATA_W) begin : g_bad_pc
         $error("stk_engine: PC_W must be twice DATA_W");
      end
      if (PTR_W < 3 || PTR_W >= ADDR_W) begin : g_bad_ptr
         $error("stk_engine: PTR_W out of range");
      end
   endgenerate

   op_e               op_q;
   logic [STEP_W-1:0] step_q;
   logic              busy_q, start, rsp_go, push_act, pull_act;
   logic [PTR_W-1:0]  sp_q, sp_up;
   sel_e              sel;

   stk_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rsp_cmd  (rsp_cmd),
      .call_req (call_req),
      .intr_req (intr_req),
      .ret_req  (ret_req),
      .reti_req (reti_req),
      .op_q     (op_q),
      .step_q   (step_q),
      .busy_q   (busy_q),
      .start    (start),
      .rsp_go   (rsp_go),
      .done_q   (done)
   );

   assign push_act = busy_q && is_push(op_q);
   assign pull_act = busy_q && !is_push(op_q);
   assign sel      = byte_sel(op_q, step_q);

   stk_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_top (rsp_go),
      .dec      (push_act),
      .inc      (pull_act),
      .sp_q     (sp_q),
      .sp_up    (sp_up)
   );

   stk_frame #(.DATA_W(DATA_W), .PC_W(PC_W), .SNAPSHOT(SNAPSHOT)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (start),
      .pc_in   (pc_in),
      .x_in    (x_in),
      .acc_in  (acc_in),
      .ccr_in  (ccr_in),
      .sel     (sel),
      .wdata   (mem_wdata)
   );

   stk_restore #(.DATA_W(DATA_W), .PC_W(PC_W)) u_restore (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (pull_act),
      .sel     (sel),
      .rdata   (mem_rdata),
      .pc_out  (pc_out),
      .x_out   (x_out),
      .acc_out (acc_out),
      .ccr_out (ccr_out)
   );

   assign mem_addr = {PAGE_VAL, (pull_act ? sp_up : sp_q)};
   assign mem_we   = push_act;
   assign mem_re   = pull_act;

   // R9
   no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R3
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (mem_addr[PTR_W-1:0] ==
                  $past(mem_addr[PTR_W-1:0]) - {{(PTR_W-1){1'b0}}, 1'b1}));

   // R1
   rsp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_go |=> (mem_addr == {PAGE_VAL, {PTR_W{1'b1}}}));

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(mem_we || mem_re) || start);

   // R2
   page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (mem_addr[ADDR_W-1:PTR_W] == PAGE_W'(PAGE_VAL)));

endmodule

// File: tb/test_stk_engine.sv
module test_stk_engine;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rsp_cmd, call_req, intr_req, ret_req, reti_req;
   logic [15:0] pc_in;
   logic [7:0]  x_in, acc_in, ccr_in, mem_rdata;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we, mem_re, done;
   logic [15:0] pc_out;
   logic [7:0]  x_out, acc_out, ccr_out;

   int   nvec = 0;
   int   nbad = 0;
   logic [5:0] rp;
   logic [7:0] shadow [64];
   logic [7:0] mem    [64];

   // request vector order: {rsp, intr, call, reti, ret}
   localparam logic [4:0] Q_RSP  = 5'b10000;
   localparam logic [4:0] Q_INTR = 5'b01000;
   localparam logic [4:0] Q_CALL = 5'b00100;
   localparam logic [4:0] Q_RETI = 5'b00010;
   localparam logic [4:0] Q_RET  = 5'b00001;

   always #5 clk = ~clk;

   stk_engine i_stk_engine (
      .clk(clk), .rst_n(rst_n), .rsp_cmd(rsp_cmd), .call_req(call_req),
      .intr_req(intr_req), .ret_req(ret_req), .reti_req(reti_req),
      .pc_in(pc_in), .x_in(x_in), .acc_in(acc_in), .ccr_in(ccr_in),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_re(mem_re), .pc_out(pc_out), .x_out(x_out),
      .acc_out(acc_out), .ccr_out(ccr_out), .done(done)
   );

   always @(posedge clk) if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
   assign mem_rdata = mem[mem_addr[5:0]];

   function automatic logic [15:0] at(logic [5:0] p);
      return {10'b0000000011, p};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic set_req(input logic [4:0] q);
      {rsp_cmd, intr_req, call_req, reti_req, ret_req} = q;
   endtask

   task automatic push_seq(input logic [4:0] q, input bit intr, input logic [15:0] pc,
                           input logic [7:0] x, input logic [7:0] a, input logic [7:0] c,
                           input bit disturb);
      logic [7:0] fb [5];
      int n;
      fb[0] = pc[7:0]; fb[1] = pc[15:8]; fb[2] = x; fb[3] = a; fb[4] = c;
      n = intr ? 5 : 2;
      pc_in = pc; x_in = x; acc_in = a; ccr_in = c;
      set_req(q);
      @(negedge clk);
      set_req(5'b0);
      if (disturb) begin
         pc_in = ~pc; x_in = ~x; acc_in = ~a; ccr_in = ~c;
      end
      for (int k = 0; k < n; k++) begin
         chk("R9", {mem_we, mem_re}, 2'b10);
         if (disturb) chk("R14", mem_wdata, fb[k]);
         else if (intr) chk("R6", mem_wdata, fb[k]);
         else chk("R5", mem_wdata, fb[k]);
         chk("R3", mem_addr, at(rp));
         chk("R10", done, 0);
         shadow[rp] = fb[k];
         rp = rp - 6'd1;
         if (disturb && k == 1) set_req(5'b11111);
         @(negedge clk);
         set_req(5'b0);
      end
      chk("R10", done, 1);
      chk("R9", {mem_we, mem_re}, 2'b00);
      if (disturb) chk("R11", mem_addr, at(rp));
      else chk("R13", mem_addr, at(rp));
   endtask

   task automatic pull_seq(input logic [4:0] q, input bit reti);
      logic [7:0] e [5];
      int n;
      n = reti ? 5 : 2;
      set_req(q);
      @(negedge clk);
      set_req(5'b0);
      for (int k = 0; k < n; k++) begin
         rp = rp + 6'd1;
         chk("R3", mem_addr, at(rp));
         chk("R9", {mem_we, mem_re}, 2'b01);
         chk("R10", done, 0);
         e[k] = shadow[rp];
         @(negedge clk);
      end
      chk("R10", done, 1);
      if (reti) begin
         chk("R8", ccr_out, e[0]);
         chk("R8", acc_out, e[1]);
         chk("R8", x_out, e[2]);
         chk("R8", pc_out, {e[3], e[4]});
      end else begin
         chk("R7", pc_out, {e[0], e[1]});
      end
   endtask

   task automatic rsp_seq(input logic [4:0] q);
      set_req(q);
      @(negedge clk);
      set_req(5'b0);
      rp = 6'h3F;
      chk("R12", mem_addr, 16'h00FF);
      chk("R12", {mem_we, mem_re}, 2'b00);
      @(negedge clk);
      chk("R1", mem_addr, 16'h00FF);
      chk("R12", done, 0);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nvec++;
      nbad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      set_req(5'b0);
      pc_in = '0; x_in = '0; acc_in = '0; ccr_in = '0;
      rp = 6'h3F;
      for (int i = 0; i < 64; i++) begin shadow[i] = '0; mem[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", mem_addr, 16'h00FF);
      chk("R1", {mem_we, mem_re, done}, 3'b000);
      chk("R1", pc_out, 16'h0000);

      // nested calls with an interrupt frame inside each level
      for (int i = 0; i < 6; i++) begin
         push_seq(Q_CALL, 1'b0, 16'h1234 + 16'(i) * 16'h1111, 8'h00, 8'h00, 8'h00, 1'b0);
         push_seq(Q_INTR, 1'b1, 16'hA05C ^ 16'(i * 37), 8'(8'h11 * i), 8'(8'h3C + i), 8'(8'hE0 | i), 1'b0);
         pull_seq(Q_RETI, 1'b1);
      end
      for (int i = 0; i < 6; i++) pull_seq(Q_RET, 1'b0);
      @(negedge clk);
      chk("R9", {mem_we, mem_re, done}, 3'b000);

      // requests and input changes in the middle of an interrupt push
      push_seq(Q_INTR, 1'b1, 16'h5AA5, 8'h77, 8'h88, 8'h99, 1'b1);
      pull_seq(Q_RETI, 1'b1);

      // priority among simultaneous requests
      rsp_seq(5'b11111);
      push_seq(5'b01111, 1'b1, 16'hBEEF, 8'h01, 8'h02, 8'h03, 1'b0);
      push_seq(5'b00111, 1'b0, 16'hC0DE, 8'h00, 8'h00, 8'h00, 1'b0);
      pull_seq(5'b00011, 1'b1);
      pull_seq(Q_RET, 1'b0);

      // wrap-around over the 64-byte page
      rsp_seq(Q_RSP);
      for (int i = 0; i < 40; i++) begin
         push_seq(Q_CALL, 1'b0, 16'(i) * 16'h0101 + 16'h0003, 8'h00, 8'h00, 8'h00, 1'b0);
         if (i == 31) chk("R4", mem_addr, 16'h00FF);
      end
      chk("R4", mem_addr, at(rp));
      for (int i = 0; i < 40; i++) pull_seq(Q_RET, 1'b0);
      chk("R4", mem_addr, at(rp));

      @(negedge clk);
      summary();
      $finish;
   end

endmodule